// File: doc/BRIEF.md
# Late-Result Load Interlock Unit

This unit sits between Decode and Execute in a five-stage in-order pipeline where byte, halfword and misaligned word loads finish their data alignment in the last stage. Their result is therefore one cycle late for a normal bypass. Each cycle the unit looks at the decoded instruction offered to Execute. It keeps a small record of the most recent late-result load and requests a one-cycle hold of Decode when one of the next two issued instructions reads that load's destination.

The hold is requested combinationally, from the Decode operands and the record. One cycle later the unit raises a registered bubble flag, and the pipeline puts an invalid instruction into Execute in that cycle. The record is dropped in any of these cases:
- a hold has been taken for it;
- two further instructions have issued;
- a multi-cycle instruction issues;
- Execute reports it is busy;
- the pipeline is flushed.

Top module: `lateload_interlock`

## Requirements
- R1: An aligned word load (kind code 1) never opens a hazard. A reader of its destination that issues right after it gets no stall.
- R2: A byte (kind 2), halfword (kind 3) or misaligned word (kind 4) load followed at once by a reader of its destination stalls that reader for exactly one cycle. A match on any valid source field counts.
- R3: The reader still stalls for one cycle when one independent instruction issues between the load and the reader.
- R4: A reader that is the third or a later instruction issued after the load does not stall.
- R5: Once one stall has been taken for a load, later readers of the same register do not stall.
- R6: A multi-cycle instruction (id_multi_i high) that issues between the load and the reader cancels the hazard.
- R7: While ex_busy_i is high, stall_o stays low and the pending hazard is discarded.
- R8: A block store (id_blk_i high) stalls when bit d of id_list_i is set, where d is the pending destination. It does not stall when that bit is clear.
- R9: Register 15 never matches, whether it is the load destination or a source. A source field whose bit in id_src_vld_i is low never matches.
- R10: While flush_i is high, stall_o is low and the pending hazard is discarded.
- R11: bubble_o is high in exactly the cycle after a cycle in which stall_o was high.
- R12: After a synchronous reset, stall_o and bubble_o are low and no hazard is pending.
- R13: A new late-result load that issues while a hazard is pending replaces the old record, so only the newest destination can stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Pipeline flush; discards the record |
| ex_busy_i | input | 1 | Execute is held by a multi-cycle instruction |
| id_valid_i | input | 1 | Decode holds a valid instruction |
| id_kind_i | input | 3 | 0 other, 1 aligned word load, 2 byte load, 3 halfword load, 4 misaligned word load |
| id_dst_i | input | REG_W | Destination register of the Decode instruction |
| id_src_vld_i | input | NSRC | Valid bit per source field |
| id_src_i | input | NSRC*REG_W | Source fields; field i occupies bits [i*REG_W +: REG_W] |
| id_blk_i | input | 1 | Decode instruction is a block store |
| id_list_i | input | 2**REG_W | Register list of a block store, bit n = register n |
| id_multi_i | input | 1 | Decode instruction takes more than one Execute cycle |
| stall_o | output | 1 | Hold Decode this cycle (combinational) |
| bubble_o | output | 1 | Inject an invalid instruction into Execute this cycle |

## Verification
The hardest case to reach from the ports is the second-slot consumer. A late load, then an unrelated instruction, then the reader must issue back to back, with no invalid slot, busy cycle or multi-cycle instruction in between, so that the record survives the first slot. The stimulus table plays such runs cycle by cycle and repeats the stalled instruction the way a held Decode stage would. Runs that differ by one element sit next to them: a third-slot reader, an intervening multi-cycle instruction, and a second late load that replaces the first. Together they separate expiry, cancellation and replacement.

// File: rtl/lu_pkg.sv
package lu_pkg;
  typedef enum logic [2:0] {
    KIND_OTHER = 3'd0,
    KIND_WORD  = 3'd1,
    KIND_BYTE  = 3'd2,
    KIND_HALF  = 3'd3,
    KIND_MISAL = 3'd4
  } kind_e;

  function automatic logic is_late(input logic [2:0] k);
    return (k == KIND_BYTE) || (k == KIND_HALF) || (k == KIND_MISAL);
  endfunction
endpackage

// File: rtl/lu_match.sv
module lu_match #(
  parameter int REG_W = 4,
  parameter int NSRC  = 3,
  localparam int NREGS = 1 << REG_W
) (
  input  logic                  pend_vld_i,
  input  logic [REG_W-1:0]      pend_reg_i,
  input  logic [NSRC-1:0]       src_vld_i,
  input  logic [NSRC*REG_W-1:0] src_i,
  input  logic                  blk_i,
  input  logic [NREGS-1:0]      list_i,
  output logic                  hit_o
);
  localparam logic [REG_W-1:0] PC_REG = REG_W'(NREGS - 1);

  logic [NSRC-1:0] src_hit;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic [REG_W-1:0] fld;
      assign fld        = src_i[i*REG_W +: REG_W];
      assign src_hit[i] = src_vld_i[i] && (fld == pend_reg_i) && (fld != PC_REG);
    end
  endgenerate

  logic list_hit;
  assign list_hit = blk_i && list_i[pend_reg_i] && (pend_reg_i != PC_REG);

  assign hit_o = pend_vld_i && ((|src_hit) || list_hit);
endmodule

// File: rtl/lu_track.sv
module lu_track #(
  parameter int REG_W  = 4,
  parameter int WINDOW = 2,
  localparam int NREGS = 1 << REG_W,
  localparam int CNT_W = $clog2(WINDOW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             flush_i,
  input  logic             busy_i,
  input  logic             stall_i,
  input  logic             issue_i,
  input  logic             late_i,
  input  logic             word_i,
  input  logic             multi_i,
  input  logic [REG_W-1:0] dst_i,
  output logic             pend_vld_o,
  output logic [REG_W-1:0] pend_reg_o
);
  localparam logic [REG_W-1:0] PC_REG  = REG_W'(NREGS - 1);
  localparam logic [CNT_W-1:0] LAST_SL = CNT_W'(WINDOW - 1);

  logic             vld_q;
  logic [REG_W-1:0] reg_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i || busy_i || stall_i) begin
      vld_q <= 1'b0;
      cnt_q <= '0;
    end else if (issue_i) begin
      if (late_i) begin
        vld_q <= (dst_i != PC_REG);
        reg_q <= dst_i;
        cnt_q <= '0;
      end else if (vld_q) begin
        if (multi_i || cnt_q == LAST_SL) begin
          vld_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign pend_vld_o = vld_q;
  assign pend_reg_o = reg_q;

  AST_WORD_NO_OPEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (issue_i && word_i && !vld_q) |=> !vld_q); // R1
  AST_WINDOW_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    vld_q |-> (cnt_q < CNT_W'(WINDOW))); // R4
  AST_MULTI_CANCEL: assert property (@(posedge clk_i) disable iff (rst_i)
    (issue_i && multi_i && !late_i) |=> !vld_q); // R6
  AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_i |=> !vld_q); // R7
  AST_PC_NEVER_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    vld_q |-> (reg_q != PC_REG)); // R9
  AST_FLUSH_DROP: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |=> !vld_q); // R10
  AST_NEWEST_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    (issue_i && late_i && dst_i != PC_REG && !flush_i && !busy_i && !stall_i)
      |=> (vld_q && reg_q == $past(dst_i))); // R13
endmodule

// File: rtl/lateload_interlock.sv
module lateload_interlock #(
  parameter int REG_W  = 4,
  parameter int NSRC   = 3,
  parameter int WINDOW = 2,
  localparam int NREGS = 1 << REG_W
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  flush_i,
  input  logic                  ex_busy_i,
  input  logic                  id_valid_i,
  input  logic [2:0]            id_kind_i,
  input  logic [REG_W-1:0]      id_dst_i,
  input  logic [NSRC-1:0]       id_src_vld_i,
  input  logic [NSRC*REG_W-1:0] id_src_i,
  input  logic                  id_blk_i,
  input  logic [NREGS-1:0]      id_list_i,
  input  logic                  id_multi_i,
  output logic                  stall_o,
  output logic                  bubble_o
);
  import lu_pkg::*;

  logic             pend_vld;
  logic [REG_W-1:0] pend_reg;
  logic             hit;
  logic             issue;
  logic             bubble_q;

  lu_match #(.REG_W(REG_W), .NSRC(NSRC)) u_match (
    .pend_vld_i (pend_vld),
    .pend_reg_i (pend_reg),
    .src_vld_i  (id_src_vld_i),
    .src_i      (id_src_i),
    .blk_i      (id_blk_i),
    .list_i     (id_list_i),
    .hit_o      (hit)
  );

  assign stall_o = id_valid_i && hit && !ex_busy_i && !flush_i;
  assign issue   = id_valid_i && !stall_o && !ex_busy_i && !flush_i;

  lu_track #(.REG_W(REG_W), .WINDOW(WINDOW)) u_track (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .flush_i    (flush_i),
    .busy_i     (ex_busy_i),
    .stall_i    (stall_o),
    .issue_i    (issue),
    .late_i     (is_late(id_kind_i)),
    .word_i     (id_kind_i == KIND_WORD),
    .multi_i    (id_multi_i),
    .dst_i      (id_dst_i),
    .pend_vld_o (pend_vld),
    .pend_reg_o (pend_reg)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) bubble_q <= 1'b0;
    else       bubble_q <= stall_o;
  end

  assign bubble_o = bubble_q;

  AST_SINGLE_STALL: assert property (@(posedge clk_i) disable iff (rst_i)
    stall_o |=> !stall_o); // R5
  AST_BUBBLE_AFTER: assert property (@(posedge clk_i) disable iff (rst_i)
    stall_o |=> bubble_o); // R11
  AST_NO_STRAY_BUBBLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !stall_o |=> !bubble_o); // R11
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    rst_i |=> !bubble_o); // R12
endmodule

// File: tb/lateload_interlock_tb.sv
module lateload_interlock_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        flush, busy, vld, blk, mul;
  logic [2:0]  kind;
  logic [3:0]  dst;
  logic [2:0]  svld;
  logic [11:0] src;
  logic [15:0] lst;
  logic        stall, bubble;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  lateload_interlock u_dut (
    .clk_i(clk), .rst_i(rst), .flush_i(flush), .ex_busy_i(busy),
    .id_valid_i(vld), .id_kind_i(kind), .id_dst_i(dst),
    .id_src_vld_i(svld), .id_src_i(src), .id_blk_i(blk),
    .id_list_i(lst), .id_multi_i(mul), .stall_o(stall), .bubble_o(bubble)
  );

  typedef struct packed {
    logic       v;
    logic [2:0] k;
    logic [3:0] d;
    logic [2:0] sv;
    logic [3:0] s0, s1, s2;
    logic       b;
    logic [15:0] l;
    logic       m, bz, fl;
    logic       xs, xb;
    logic [7:0] rq;
  } vec_t;

  localparam int NV = 40;
  // v k d sv s0 s1 s2 blk list mul busy flush exp_stall exp_bubble req
  localparam vec_t TBL [NV] = '{
    '{1,1,0,0,0,0,0,0,0,0,0,0,0,0,1},      // R1 aligned word load r0
    '{1,0,1,1,0,0,0,0,0,0,0,0,0,0,1},      // R1 reader, no stall
    '{1,2,0,0,0,0,0,0,0,0,0,0,0,0,2},      // R2 byte load r0
    '{1,0,1,1,0,0,0,0,0,0,0,0,1,0,2},      // R2 reader stalls
    '{1,0,1,1,0,0,0,0,0,0,0,0,0,1,11},     // R11 bubble, reader issues
    '{1,0,1,2,0,0,0,0,0,0,0,0,0,0,5},      // R5 second reader free
    '{1,3,1,0,0,0,0,0,0,0,0,0,0,0,3},      // R3 halfword load r1
    '{1,0,2,1,5,0,0,0,0,0,0,0,0,0,3},      // R3 independent
    '{1,0,3,2,0,1,0,0,0,0,0,0,1,0,3},      // R3 second slot stalls
    '{1,0,3,2,0,1,0,0,0,0,0,0,0,1,3},      // R3 bubble
    '{1,4,2,0,0,0,0,0,0,0,0,0,0,0,4},      // R4 misaligned load r2
    '{1,0,3,1,7,0,0,0,0,0,0,0,0,0,4},      // R4 slot one
    '{1,0,3,1,8,0,0,0,0,0,0,0,0,0,4},      // R4 slot two
    '{1,0,3,1,2,0,0,0,0,0,0,0,0,0,4},      // R4 third slot reader free
    '{1,2,3,0,0,0,0,0,0,0,0,0,0,0,6},      // R6 byte load r3
    '{1,0,4,1,6,0,0,0,0,1,0,0,0,0,6},      // R6 multi-cycle
    '{1,0,4,1,3,0,0,0,0,0,0,0,0,0,6},      // R6 reader free
    '{1,2,4,0,0,0,0,0,0,0,0,0,0,0,7},      // R7 byte load r4
    '{1,0,5,1,4,0,0,0,0,0,1,0,0,0,7},      // R7 busy, no stall
    '{1,0,5,1,4,0,0,0,0,0,0,0,0,0,7},      // R7 hazard gone
    '{1,2,5,0,0,0,0,0,0,0,0,0,0,0,8},      // R8 byte load r5
    '{1,0,0,0,0,0,0,1,16'h0030,1,0,0,1,0,8}, // R8 list has r5
    '{1,0,0,0,0,0,0,1,16'h0030,1,0,0,0,1,8}, // R8 bubble
    '{1,2,6,0,0,0,0,0,0,0,0,0,0,0,8},      // R8 byte load r6
    '{1,0,0,0,0,0,0,1,16'h0003,1,0,0,0,0,8}, // R8 list lacks r6
    '{1,2,15,0,0,0,0,0,0,0,0,0,0,0,9},     // R9 load to r15
    '{1,0,1,1,15,0,0,0,0,0,0,0,0,0,9},     // R9 r15 reader free
    '{1,2,7,0,0,0,0,0,0,0,0,0,0,0,9},      // R9 byte load r7
    '{1,0,1,0,7,7,7,0,0,0,0,0,0,0,9},      // R9 invalid fields
    '{1,0,1,4,0,0,7,0,0,0,0,0,1,0,2},      // R2 third field match
    '{1,0,1,4,0,0,7,0,0,0,0,0,0,1,2},      // R2 bubble
    '{1,2,8,0,0,0,0,0,0,0,0,0,0,0,10},     // R10 byte load r8
    '{1,0,1,1,8,0,0,0,0,0,0,1,0,0,10},     // R10 flush, no stall
    '{1,0,1,1,8,0,0,0,0,0,0,0,0,0,10},     // R10 hazard gone
    '{1,2,9,0,0,0,0,0,0,0,0,0,0,0,13},     // R13 byte load r9
    '{1,3,10,0,0,0,0,0,0,0,0,0,0,0,13},    // R13 halfword load r10
    '{1,0,1,1,9,0,0,0,0,0,0,0,0,0,13},     // R13 old dest free
    '{1,0,1,1,10,0,0,0,0,0,0,0,1,0,13},    // R13 new dest stalls
    '{1,0,1,1,10,0,0,0,0,0,0,0,0,1,13},    // R13 bubble
    '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,11}      // R11 idle
  };

  task automatic drive(input vec_t t);
    vld = t.v; kind = t.k; dst = t.d; svld = t.sv;
    src = {t.s2, t.s1, t.s0}; blk = t.b; lst = t.l;
    mul = t.m; busy = t.bz; flush = t.fl;
  endtask

  task automatic check(input int rq, input logic xs, input logic xb, input int step);
    n_chk++;
    if (stall !== xs || bubble !== xb) begin
      n_fail++;
      $display("FAIL R%0d step %0d: stall=%b bubble=%b expected stall=%b bubble=%b",
               rq, step, stall, bubble, xs, xb);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    vec_t z;
    z = '0;
    rst = 1'b1;
    drive(z);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12: reset state, a reader of r0 finds nothing pending
    z.v = 1; z.sv = 3'b001;
    drive(z);
    #1 check(12, 1'b0, 1'b0, -1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #1 check(int'(TBL[i].rq), TBL[i].xs, TBL[i].xb, i);
    end

    // R12: reset while a hazard is pending clears it
    @(negedge clk);
    z = '0; z.v = 1; z.k = 3'd2; z.d = 4'd11;
    drive(z);
    @(negedge clk);
    z = '0; z.v = 1; z.sv = 3'b001; z.s0 = 4'd11;
    drive(z);
    #1 check(2, 1'b1, 1'b0, 100);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 check(12, 1'b0, 1'b0, 101);

    // R9: r15 in a block store list never matches
    @(negedge clk);
    z = '0; z.v = 1; z.k = 3'd4; z.d = 4'd15;
    drive(z);
    @(negedge clk);
    z = '0; z.v = 1; z.b = 1; z.l = 16'h8000; z.m = 1;
    drive(z);
    #1 check(9, 1'b0, 1'b0, 102);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule